// File: doc/BRIEF.md
# Dual-Width Microcoded ALU

This block is the combinational arithmetic and logic unit of a small microcoded datapath. It takes two 16-bit operands and produces a 16-bit result together with zero, sign, overflow and carry flags. The operation comes from a 2-bit microcode select field. That field either passes through a 3-bit function code taken from the instruction register or forces one of three operations: AND, SUB or ADD. Forcing lets compare sequences reuse SUB and lets a register copy run as an AND with an all-ones operand, wherever those instructions sit in the opcode map.

A size bit chooses between 8-bit and 16-bit operation. In 8-bit mode only the low bytes of the operands matter. The flags describe the 8-bit result, and the upper result byte repeats bit 7. A carry-in select bit chooses between a carry-in of zero and the stored carry flag, which gives add-with-carry and subtract-with-carry. The flag register, the bus drivers and the wider instruction decode sit outside this block.

The block has no clock and no state. Every output follows its inputs within the same cycle.

Top module: `alu_dualwidth`

## Requirements
- R1: `op_sel` selects the operation: 2'b00 uses the function code on `ir_func`, 2'b01 forces AND, 2'b10 forces SUB and 2'b11 forces ADD. When `op_sel` is nonzero, `ir_func` has no effect.
- R2: Function codes on `ir_func`: 3'd2 = left minus right, 3'd3 = left plus right, 3'd4 = XOR, 3'd5 = OR, 3'd6 = AND.
- R3: With `cin_sel`=0 the carry-in is 0 for ADD and 1 for SUB, so `carry_flag` has no effect. With `cin_sel`=1, `carry_flag` is the carry-in for both. In SUB, `carry_flag`=0 takes one extra borrow.
- R4: The carry flag `flag_c` is the carry out of bit 7 (8-bit mode) or bit 15 (16-bit mode) of left + right (ADD) or left + ~right (SUB). For SUB, 1 therefore means no borrow.
- R5: The overflow flag `flag_v` is the signed overflow of ADD or SUB at the active width. For XOR, OR and AND, both `flag_v` and `flag_c` are 0.
- R6: The zero flag `flag_z` is 1 exactly when the active-width result is all zeros. The sign flag `flag_s` is the top bit of the active-width result.
- R7: With `wide`=0 the operation uses only the operands' bits 7:0, and result bits 15:8 all equal result bit 7. With `wide`=1 all 16 bits are used.
- R8: Function codes 3'd0, 3'd1 and 3'd7 (with `op_sel`=2'b00) give a zero result with `flag_z`=1 and `flag_s`, `flag_v`, `flag_c` all 0.
- R9: A forced AND with `opnd_r` = 16'hFFFF copies `opnd_l` to the result (sign-extended from bit 7 in 8-bit mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_l | input | 16 | Left operand |
| opnd_r | input | 16 | Right operand (subtrahend for SUB) |
| ir_func | input | 3 | Function code from instruction register bits 1 to 3 |
| op_sel | input | 2 | Microcode operation select |
| cin_sel | input | 1 | 0: fixed carry-in, 1: stored carry as carry-in |
| wide | input | 1 | 0: 8-bit operation, 1: 16-bit operation |
| carry_flag | input | 1 | Stored carry flag |
| result | output | 16 | Operation result |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / no-borrow flag |

## Verification
The bench targets the carry boundaries: 16'hFFFF+1 and 8'hFF+1 (a design that takes carry from the wrong bit reports a nonzero result or loses C), 16'h7FFF+1 and 16'h8000-1 (a wrong overflow formula misses V), and equal-operand subtraction (an inverted borrow sense clears C). In 8-bit mode the upper operand bytes are chosen so that their sum or difference is visibly nonzero. A design that leaks them shows wrong upper result bits or a wrong zero flag. Subtract-with-carry runs with the stored carry both set and clear, which catches a carry-in select with the wrong polarity. Forced selects are swept over all eight function codes, so any path that lets `ir_func` through changes the result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        FN_RSV0 = 3'd0,
        FN_RSV1 = 3'd1,
        FN_SUB  = 3'd2,
        FN_ADD  = 3'd3,
        FN_XOR  = 3'd4,
        FN_OR   = 3'd5,
        FN_AND  = 3'd6,
        FN_RSV7 = 3'd7
    } alu_fn_e;

    typedef enum logic [1:0] {
        SEL_IR  = 2'b00,
        SEL_AND = 2'b01,
        SEL_SUB = 2'b10,
        SEL_ADD = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic z;
        logic s;
        logic v;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
    import alu_pkg::*;
(
    input  logic [2:0] ir_func,
    input  logic [1:0] op_sel,
    input  logic       cin_sel,
    input  logic       carry_flag,
    output alu_fn_e    fn,
    output logic       is_arith,
    output logic       is_logic,
    output logic       is_sub,
    output logic       carry_in
);

    alu_sel_e sel;

    always_comb begin
        sel = alu_sel_e'(op_sel);
        unique case (sel)
            SEL_IR:  fn = alu_fn_e'(ir_func);
            SEL_AND: fn = FN_AND;
            SEL_SUB: fn = FN_SUB;
            SEL_ADD: fn = FN_ADD;
            default: fn = FN_RSV0;
        endcase
    end

    always_comb begin
        is_sub   = (fn == FN_SUB);
        is_arith = (fn == FN_SUB) || (fn == FN_ADD);
        is_logic = (fn == FN_XOR) || (fn == FN_OR) || (fn == FN_AND);
        if (cin_sel) begin
            carry_in = carry_flag;
        end else begin
            carry_in = is_sub;
        end
    end

    // R1: a forced select always lands on one of the three forced operations
    always_comb begin
        if (op_sel != 2'b00) begin
            a_r1_forced_op: assert (fn == FN_AND || fn == FN_SUB || fn == FN_ADD)
                else $error("forced select produced function %0d", fn);
        end
    end

endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide_sum;

    always_comb begin
        b_eff    = sub ? ~b : b;
        wide_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum      = wide_sum[W-1:0];
        cout     = wide_sum[W];
        ovf      = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (fn)
            FN_XOR:  y = a ^ b;
            FN_OR:   y = a | b;
            FN_AND:  y = a & b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu_dualwidth.sv
module alu_dualwidth
    import alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int FUNC_W   = 3
) (
    input  logic [DATA_W-1:0] opnd_l,
    input  logic [DATA_W-1:0] opnd_r,
    input  logic [FUNC_W-1:0] ir_func,
    input  logic [1:0]        op_sel,
    input  logic              cin_sel,
    input  logic              wide,
    input  logic              carry_flag,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_v,
    output logic              flag_c
);

    localparam int EXT_W = DATA_W - NARROW_W;

    alu_fn_e fn;
    logic    is_arith;
    logic    is_logic;
    logic    is_sub;
    logic    carry_in;

    alu_func_decode u_decode (
        .ir_func    (ir_func),
        .op_sel     (op_sel),
        .cin_sel    (cin_sel),
        .carry_flag (carry_flag),
        .fn         (fn),
        .is_arith   (is_arith),
        .is_logic   (is_logic),
        .is_sub     (is_sub),
        .carry_in   (carry_in)
    );

    // One adder per supported width, so carry and overflow come straight
    // from the active width's top bit.
    logic [DATA_W-1:0]   sum_w;
    logic [NARROW_W-1:0] sum_n;
    logic                cout_w, cout_n, ovf_w, ovf_n;

    generate
        if (NARROW_W < DATA_W) begin : g_two_adders
            alu_arith #(.W(DATA_W)) u_add_wide (
                .a    (opnd_l),
                .b    (opnd_r),
                .sub  (is_sub),
                .cin  (carry_in),
                .sum  (sum_w),
                .cout (cout_w),
                .ovf  (ovf_w)
            );
            alu_arith #(.W(NARROW_W)) u_add_narrow (
                .a    (opnd_l[NARROW_W-1:0]),
                .b    (opnd_r[NARROW_W-1:0]),
                .sub  (is_sub),
                .cin  (carry_in),
                .sum  (sum_n),
                .cout (cout_n),
                .ovf  (ovf_n)
            );
        end else begin : g_bad_widths
            initial $error("NARROW_W must be smaller than DATA_W");
            assign sum_w  = '0;
            assign sum_n  = '0;
            assign cout_w = 1'b0;
            assign cout_n = 1'b0;
            assign ovf_w  = 1'b0;
            assign ovf_n  = 1'b0;
        end
    endgenerate

    logic [DATA_W-1:0] logic_y;

    alu_logic_unit #(.W(DATA_W)) u_logic (
        .a  (opnd_l),
        .b  (opnd_r),
        .fn (fn),
        .y  (logic_y)
    );

    function automatic logic [DATA_W-1:0] sext_narrow(input logic [NARROW_W-1:0] x);
        return {{EXT_W{x[NARROW_W-1]}}, x};
    endfunction

    logic [DATA_W-1:0] res_pre;
    alu_flags_t        fl;

    always_comb begin
        res_pre = '0;
        fl      = '0;
        if (is_arith) begin
            res_pre = wide ? sum_w  : sext_narrow(sum_n);
            fl.c    = wide ? cout_w : cout_n;
            fl.v    = wide ? ovf_w  : ovf_n;
        end else if (is_logic) begin
            res_pre = wide ? logic_y : sext_narrow(logic_y[NARROW_W-1:0]);
        end
        fl.z = (res_pre == '0);
        fl.s = res_pre[DATA_W-1];
    end

    assign result = res_pre;
    assign flag_z = fl.z;
    assign flag_s = fl.s;
    assign flag_v = fl.v;
    assign flag_c = fl.c;

    always_comb begin
        if (!wide) begin
            a_r7_sign_ext: assert (result[DATA_W-1:NARROW_W] == {EXT_W{result[NARROW_W-1]}})
                else $error("upper result byte is not a sign extension");
        end
        if (is_logic) begin
            a_r5_logic_no_vc: assert (!flag_v && !flag_c)
                else $error("logic operation left V or C set");
        end
        if (!is_arith && !is_logic) begin
            a_r8_unused_zero: assert (result == '0 && flag_z && !flag_s && !flag_v && !flag_c)
                else $error("unused function code gave a nonzero outcome");
        end
        a_r6_zero_flag: assert (flag_z == (result == '0))
            else $error("zero flag disagrees with result");
        a_r6_sign_flag: assert (flag_s == result[DATA_W-1])
            else $error("sign flag disagrees with result");
    end

endmodule

// File: tb/tb_alu_dualwidth.sv
module tb_alu_dualwidth;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [15:0] opnd_l = '0;
    logic [15:0] opnd_r = '0;
    logic [2:0]  ir_func = '0;
    logic [1:0]  op_sel = '0;
    logic        cin_sel = 1'b0;
    logic        wide = 1'b0;
    logic        carry_flag = 1'b0;
    logic [15:0] result;
    logic        flag_z, flag_s, flag_v, flag_c;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    alu_dualwidth dut (
        .opnd_l     (opnd_l),
        .opnd_r     (opnd_r),
        .ir_func    (ir_func),
        .op_sel     (op_sel),
        .cin_sel    (cin_sel),
        .wide       (wide),
        .carry_flag (carry_flag),
        .result     (result),
        .flag_z     (flag_z),
        .flag_s     (flag_s),
        .flag_v     (flag_v),
        .flag_c     (flag_c)
    );

    // {left, right, ir, sel, cin_sel, wide, carry_flag, result, z s v c}
    localparam int NV = 31;
    localparam logic [59:0] VEC [0:NV-1] = '{
        {16'h1234, 16'h0001, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0, 16'h1235, 4'b0000},
        {16'h7FFF, 16'h0001, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0, 16'h8000, 4'b0110},
        {16'hFFFF, 16'h0001, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0, 16'h0000, 4'b1001},
        {16'h0005, 16'h0003, 3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 16'h0002, 4'b0001},
        {16'h0003, 16'h0005, 3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 16'hFFFE, 4'b0100},
        {16'h8000, 16'h0001, 3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 16'h7FFF, 4'b0011},
        {16'h4444, 16'h4444, 3'd0, 2'b10, 1'b0, 1'b1, 1'b0, 16'h0000, 4'b1001},
        {16'hF0F0, 16'hFF00, 3'd4, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0FF0, 4'b0000},
        {16'h1200, 16'h0034, 3'd5, 2'b00, 1'b0, 1'b1, 1'b0, 16'h1234, 4'b0000},
        {16'h8F0F, 16'hF0FF, 3'd6, 2'b00, 1'b0, 1'b1, 1'b0, 16'h800F, 4'b0100},
        {16'h0010, 16'h0001, 3'd2, 2'b00, 1'b0, 1'b1, 1'b0, 16'h000F, 4'b0001},
        {16'h00FF, 16'h0001, 3'd3, 2'b00, 1'b0, 1'b1, 1'b0, 16'h0100, 4'b0000},
        {16'hABCD, 16'hFFFF, 3'd3, 2'b01, 1'b0, 1'b1, 1'b0, 16'hABCD, 4'b0100},
        {16'h0001, 16'h0001, 3'd4, 2'b11, 1'b0, 1'b1, 1'b0, 16'h0002, 4'b0000},
        {16'h1234, 16'h5678, 3'd0, 2'b00, 1'b1, 1'b1, 1'b1, 16'h0000, 4'b1000},
        {16'h1234, 16'h5678, 3'd1, 2'b00, 1'b1, 1'b1, 1'b1, 16'h0000, 4'b1000},
        {16'h1234, 16'h5678, 3'd7, 2'b00, 1'b1, 1'b0, 1'b1, 16'h0000, 4'b1000},
        {16'hAB7F, 16'hCD01, 3'd0, 2'b11, 1'b0, 1'b0, 1'b0, 16'hFF80, 4'b0110},
        {16'h12FF, 16'h3401, 3'd0, 2'b11, 1'b0, 1'b0, 1'b0, 16'h0000, 4'b1001},
        {16'h0003, 16'h0005, 3'd0, 2'b10, 1'b0, 1'b0, 1'b0, 16'hFFFE, 4'b0100},
        {16'h5A3C, 16'hFFFF, 3'd0, 2'b01, 1'b0, 1'b0, 1'b0, 16'h003C, 4'b0000},
        {16'h00C3, 16'hFFFF, 3'd0, 2'b01, 1'b0, 1'b0, 1'b0, 16'hFFC3, 4'b0100},
        {16'h0001, 16'h0001, 3'd0, 2'b11, 1'b1, 1'b1, 1'b1, 16'h0003, 4'b0000},
        {16'h0001, 16'h0001, 3'd0, 2'b11, 1'b1, 1'b1, 1'b0, 16'h0002, 4'b0000},
        {16'h0001, 16'h0001, 3'd0, 2'b11, 1'b0, 1'b1, 1'b1, 16'h0002, 4'b0000},
        {16'h0005, 16'h0003, 3'd0, 2'b10, 1'b1, 1'b1, 1'b0, 16'h0001, 4'b0001},
        {16'h0005, 16'h0003, 3'd0, 2'b10, 1'b1, 1'b1, 1'b1, 16'h0002, 4'b0001},
        {16'h0003, 16'h0003, 3'd0, 2'b10, 1'b1, 1'b1, 1'b0, 16'hFFFF, 4'b0100},
        {16'hFF0F, 16'h00F0, 3'd4, 2'b00, 1'b0, 1'b0, 1'b0, 16'hFFFF, 4'b0100},
        {16'h0000, 16'h0000, 3'd4, 2'b00, 1'b1, 1'b1, 1'b1, 16'h0000, 4'b1000},
        {16'h0080, 16'h0001, 3'd0, 2'b10, 1'b0, 1'b0, 1'b0, 16'h007F, 4'b0011}
    };

    function automatic string tag_of(input int i);
        if (i == 2)  return "R6 zero/sign at carry-out";
        if (i <= 6)  return "R4 add/sub carry and overflow";
        if (i <= 11) return "R2 instruction function codes";
        if (i == 12) return "R9 copy through forced AND";
        if (i == 13) return "R1 forced ADD overrides ir";
        if (i <= 16) return "R8 unused function codes";
        if (i <= 21) return "R7 8-bit mode";
        if (i <= 27) return "R3 carry-in select";
        if (i == 28) return "R7 upper operand bytes ignored";
        return "R5 overflow and carry at active width";
    endfunction

    task automatic check(input string tag, input logic [15:0] exp_res, input logic [3:0] exp_fl);
        logic [3:0] got_fl;
        got_fl = {flag_z, flag_s, flag_v, flag_c};
        n_checks++;
        if (result !== exp_res || got_fl !== exp_fl) begin
            n_errors++;
            $display("FAIL %s: result=%h zsvc=%b expected result=%h zsvc=%b",
                     tag, result, got_fl, exp_res, exp_fl);
        end
    endtask

    task automatic apply(input logic [15:0] l, input logic [15:0] r, input logic [2:0] f,
                         input logic [1:0] s, input logic ci, input logic w, input logic cf);
        @(negedge clk);
        opnd_l     = l;
        opnd_r     = r;
        ir_func    = f;
        op_sel     = s;
        cin_sel    = ci;
        wide       = w;
        carry_flag = cf;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R8: initial all-zero inputs select unused code 0
        @(negedge clk);
        #1;
        check("R8 initial state", 16'h0000, 4'b1000);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][59:44], VEC[i][43:28], VEC[i][27:25], VEC[i][24:23],
                  VEC[i][22], VEC[i][21], VEC[i][20]);
            check(tag_of(i), VEC[i][19:4], VEC[i][3:0]);
        end

        // R1: forced SUB and forced AND ignore every ir code
        for (int f = 0; f < 8; f++) begin
            apply(16'h0009, 16'h0004, 3'(f), 2'b10, 1'b0, 1'b1, 1'b0);
            check("R1 forced SUB ignores ir", 16'h0005, 4'b0001);
            apply(16'h0FF0, 16'h00FF, 3'(f), 2'b01, 1'b0, 1'b1, 1'b1);
            check("R1 forced AND ignores ir", 16'h00F0, 4'b0000);
        end

        // R7: same low bytes, different high bytes, 8-bit result unchanged
        apply(16'h0040, 16'h0040, 3'd0, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R7 narrow add", 16'hFF80, 4'b0110);
        apply(16'h7F40, 16'h8140, 3'd0, 2'b11, 1'b0, 1'b0, 1'b0);
        check("R7 narrow add high bytes ignored", 16'hFF80, 4'b0110);
        // same operands at 16 bits
        apply(16'h7F40, 16'h8140, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0);
        check("R7 wide add uses all bits", 16'h0080, 4'b0001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule